// File: doc/BRIEF.md
# Remote DMA Buffer Port

This block is the data window through which a host moves bytes into and out of the packet buffer of a legacy Ethernet controller. The host first loads a current remote address, a remaining byte count and a pair of ring page boundaries through a small byte-wide register port. It then issues a sequence of 8, 16 or 32 bit accesses on a single data port. Each access touches the on-chip buffer RAM at the current address, moves the address forward and the count down by the access width, and folds the address back to the first ring page when it lands on the last ring boundary.

The buffer is only partly populated: a small low region and one packet-memory window hold storage. Every other address returns all ones at the access width and drops written data. When an access brings the remaining count to zero, a completion status bit is set. This bit drives an interrupt line through a mask, and software clears it by writing a one to it.

Top module: `rdma_window`

## Requirements
- R1: An accepted access moves the remote address up and the remaining count down by 1 for size code 0 (byte), 2 for code 1 (halfword) and 4 for code 2 (word), with modulo-2^16 arithmetic.
- R2: A write access (dp_we=1) issued while the remaining count is zero changes neither the buffer contents, nor the address, nor the count.
- R3: If the address after a step equals the last ring page number times 256, it is replaced by the first ring page number times 256.
- R4: The completion bit (dma_done) is set on the clock edge of the access that leaves the count at zero. A read issued at count zero is still performed, the count wraps to 0xFFFF, and the bit is not set.
- R5: The buffer is accessed at the address with bit 0 cleared for halfwords and bits 1:0 cleared for words. The pointer still advances from the unmodified address.
- R6: Addresses 0x0000 to 0x001F and the window 0x4000 to 0x43FF are backed. Writes elsewhere are dropped. Reads elsewhere return 0xFF, 0xFFFF or 0xFFFFFFFF at the access width.
- R7: Multi-byte data is little endian: dp_wdata[7:0] goes to the lowest byte address, and read data is returned right-justified in dp_rdata with the upper unused bits zero.
- R8: irq is high exactly when dma_done is set and mask bit 6 is set. Writing register 7 with bit 6 set clears dma_done. If a clear and a completing access fall in the same cycle, the bit stays set.
- R9: A read returns its data on dp_rdata with dp_rvalid high during the cycle after the request edge. dp_rvalid is low after writes and idle cycles.
- R10: Register select codes: 0 address low byte, 1 address high byte, 2 count low byte, 3 count high byte, 4 first ring page, 5 last ring page, 6 interrupt mask, 7 status clear. When a register write and an access fall in the same cycle, the written byte replaces that register's half, and the other half keeps its value from before the step.
- R11: Size code 3 is reserved. Such a request touches neither memory, nor pointers, nor dp_rvalid.
- R12: After reset, address, count, ring pages, mask, dma_done, irq and dp_rvalid are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select code |
| cfg_wdata | input | 8 | Register write byte |
| dp_req | input | 1 | Data port access request |
| dp_we | input | 1 | 1 = write, 0 = read |
| dp_size | input | 2 | Access width code |
| dp_wdata | input | 32 | Write data, little endian |
| dp_rdata | output | 32 | Read data, right-justified |
| dp_rvalid | output | 1 | Read data valid |
| rdma_addr | output | 16 | Current remote address |
| rdma_count | output | 16 | Remaining byte count |
| dma_done | output | 1 | Completion status bit |
| irq | output | 1 | Masked interrupt |

## Verification
Two pairs of functions can act in the same clock edge. In the first pair, the final access of a transfer sets the completion bit while a status-clear write for that bit is applied. In the second, an access steps the pointer while a register write loads one byte of the address. The bench drives both stimuli in the same cycle. For the first pair it expects dma_done and irq to remain high. For the second it expects the address to take the written low byte over the pre-step high byte while the count still steps. It also reads back the buffer to confirm that the memory write used the address from before the override.

// File: rtl/rdma_pkg.sv
package rdma_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_RSVD = 2'd3
   } acc_size_e;

   typedef enum logic [2:0] {
      RS_ADDR_LO    = 3'd0,
      RS_ADDR_HI    = 3'd1,
      RS_CNT_LO     = 3'd2,
      RS_CNT_HI     = 3'd3,
      RS_RING_FIRST = 3'd4,
      RS_RING_LAST  = 3'd5,
      RS_IMASK      = 3'd6,
      RS_ISTAT_CLR  = 3'd7
   } reg_sel_e;

   function automatic logic [2:0] size_bytes(acc_size_e s);
      case (s)
         SZ_BYTE: return 3'd1;
         SZ_HALF: return 3'd2;
         SZ_WORD: return 3'd4;
         default: return 3'd0;
      endcase
   endfunction

endpackage

// File: rtl/rdma_ptr.sv
module rdma_ptr
   import rdma_pkg::*;
#(
   parameter int ADDR_W     = 16,
   parameter int PAGE_OFF_W = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       cfg_we,
   input  logic [2:0]                 cfg_sel,
   input  logic [7:0]                 cfg_wdata,
   input  logic                       step_en,
   input  logic [2:0]                 step_bytes,
   output logic [ADDR_W-1:0]          addr,
   output logic [ADDR_W-1:0]          count,
   output logic [ADDR_W-PAGE_OFF_W-1:0] ring_first,
   output logic [ADDR_W-PAGE_OFF_W-1:0] ring_last,
   output logic                       done_hit
);
   localparam int PAGE_W = ADDR_W - PAGE_OFF_W;
   localparam int HI_W   = ADDR_W - 8;

   logic [ADDR_W-1:0] addr_q, cnt_q;
   logic [ADDR_W-1:0] stepped, advanced, cnt_step;
   logic [ADDR_W-1:0] addr_nx, cnt_nx;
   logic [PAGE_W-1:0] first_q, last_q, first_nx, last_nx;
   logic [ADDR_W-1:0] last_bound, first_bound;

   assign last_bound  = {last_q,  {PAGE_OFF_W{1'b0}}};
   assign first_bound = {first_q, {PAGE_OFF_W{1'b0}}};

   always_comb begin
      stepped  = addr_q + ADDR_W'(step_bytes);
      advanced = (stepped == last_bound) ? first_bound : stepped;
      cnt_step = cnt_q - ADDR_W'(step_bytes);
      addr_nx  = step_en ? advanced : addr_q;
      cnt_nx   = step_en ? cnt_step : cnt_q;
      first_nx = first_q;
      last_nx  = last_q;
      if (cfg_we) begin
         case (reg_sel_e'(cfg_sel))
            RS_ADDR_LO:    addr_nx  = {addr_q[ADDR_W-1:8], cfg_wdata};
            RS_ADDR_HI:    addr_nx  = {cfg_wdata[HI_W-1:0], addr_q[7:0]};
            RS_CNT_LO:     cnt_nx   = {cnt_q[ADDR_W-1:8], cfg_wdata};
            RS_CNT_HI:     cnt_nx   = {cfg_wdata[HI_W-1:0], cnt_q[7:0]};
            RS_RING_FIRST: first_nx = cfg_wdata[PAGE_W-1:0];
            RS_RING_LAST:  last_nx  = cfg_wdata[PAGE_W-1:0];
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q  <= '0;
         cnt_q   <= '0;
         first_q <= '0;
         last_q  <= '0;
      end else begin
         addr_q  <= addr_nx;
         cnt_q   <= cnt_nx;
         first_q <= first_nx;
         last_q  <= last_nx;
      end
   end

   assign done_hit   = step_en && (cnt_step == '0);
   assign addr       = addr_q;
   assign count      = cnt_q;
   assign ring_first = first_q;
   assign ring_last  = last_q;
endmodule

// File: rtl/rdma_bufram.sv
module rdma_bufram
   import rdma_pkg::*;
#(
   parameter int ADDR_W     = 16,
   parameter int LOW_BYTES  = 32,
   parameter int PMEM_BASE  = 16'h4000,
   parameter int PMEM_BYTES = 1024
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_en,
   input  logic              acc_we,
   input  acc_size_e         acc_size,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic [31:0]       wdata,
   output logic [31:0]       rdata,
   output logic              rvalid
);
   localparam int LANES     = 4;
   localparam int LOW_WORDS = LOW_BYTES / LANES;
   localparam int PM_WORDS  = PMEM_BYTES / LANES;
   localparam int WORDS     = LOW_WORDS + PM_WORDS;
   localparam int IDX_W     = (WORDS > 1) ? $clog2(WORDS) : 1;
   localparam logic [ADDR_W:0] LOW_END = (ADDR_W+1)'(LOW_BYTES);
   localparam logic [ADDR_W:0] PM_LO   = (ADDR_W+1)'(PMEM_BASE);
   localparam logic [ADDR_W:0] PM_HI   = (ADDR_W+1)'(PMEM_BASE + PMEM_BYTES);

   logic [ADDR_W-1:0] aligned, pm_off, idx_full;
   logic [ADDR_W:0]   aligned_x;
   logic              in_low, in_pm, backed;
   logic [IDX_W-1:0]  word_idx;
   logic [LANES-1:0]  lane_en;
   logic [LANES-1:0][7:0] lane_wd;
   logic [LANES-1:0][7:0] lane_q;
   logic              mem_we, mem_re;

   always_comb begin
      case (acc_size)
         SZ_HALF: aligned = {acc_addr[ADDR_W-1:1], 1'b0};
         SZ_WORD: aligned = {acc_addr[ADDR_W-1:2], 2'b00};
         default: aligned = acc_addr;
      endcase
      aligned_x = {1'b0, aligned};
      in_low    = aligned_x < LOW_END;
      in_pm     = (aligned_x >= PM_LO) && (aligned_x < PM_HI);
      backed    = in_low || in_pm;
      pm_off    = aligned - ADDR_W'(PMEM_BASE);
      idx_full  = in_low ? {2'b00, aligned[ADDR_W-1:2]}
                         : ADDR_W'(LOW_WORDS) + {2'b00, pm_off[ADDR_W-1:2]};
      word_idx  = idx_full[IDX_W-1:0];
   end

   always_comb begin
      case (acc_size)
         SZ_BYTE: lane_en = 4'b0001 << aligned[1:0];
         SZ_HALF: lane_en = aligned[1] ? 4'b1100 : 4'b0011;
         default: lane_en = 4'b1111;
      endcase
   end

   assign mem_we = acc_en && acc_we && backed;
   assign mem_re = acc_en && !acc_we;

   for (genvar k = 0; k < LANES; k++) begin : g_lane
      logic [7:0] store [WORDS];
      logic [7:0] q;

      always_comb begin
         case (acc_size)
            SZ_BYTE: lane_wd[k] = wdata[7:0];
            SZ_HALF: lane_wd[k] = wdata[8*(k%2) +: 8];
            default: lane_wd[k] = wdata[8*k +: 8];
         endcase
      end

      always_ff @(posedge clk) begin
         if (mem_we && lane_en[k])
            store[word_idx] <= lane_wd[k];
         if (mem_re)
            q <= store[word_idx];
      end

      assign lane_q[k] = q;
   end

   acc_size_e rd_size_q;
   logic [1:0] rd_lo_q;
   logic       rd_backed_q, rvalid_q;
   logic [31:0] shaped;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rvalid_q    <= 1'b0;
         rd_size_q   <= SZ_BYTE;
         rd_lo_q     <= '0;
         rd_backed_q <= 1'b0;
      end else begin
         rvalid_q <= mem_re;
         if (mem_re) begin
            rd_size_q   <= acc_size;
            rd_lo_q     <= aligned[1:0];
            rd_backed_q <= backed;
         end
      end
   end

   always_comb begin
      shaped = '0;
      case (rd_size_q)
         SZ_BYTE: shaped[7:0]  = rd_backed_q ? lane_q[rd_lo_q] : 8'hFF;
         SZ_HALF: shaped[15:0] = !rd_backed_q ? 16'hFFFF :
                                 (rd_lo_q[1] ? {lane_q[3], lane_q[2]}
                                             : {lane_q[1], lane_q[0]});
         default: shaped       = rd_backed_q ? lane_q : 32'hFFFF_FFFF;
      endcase
   end

   assign rdata  = rvalid_q ? shaped : '0;
   assign rvalid = rvalid_q;
endmodule

// File: rtl/rdma_irq.sv
module rdma_irq
   import rdma_pkg::*;
#(
   parameter int STAT_W   = 8,
   parameter int DONE_BIT = 6
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       set_done,
   input  logic       cfg_we,
   input  logic [2:0] cfg_sel,
   input  logic [7:0] cfg_wdata,
   output logic       done,
   output logic       irq
);
   logic [STAT_W-1:0] mask_q;
   logic              done_q;
   logic              clr_hit;

   assign clr_hit = cfg_we && (reg_sel_e'(cfg_sel) == RS_ISTAT_CLR)
                    && cfg_wdata[DONE_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '0;
         done_q <= 1'b0;
      end else begin
         if (cfg_we && reg_sel_e'(cfg_sel) == RS_IMASK)
            mask_q <= cfg_wdata[STAT_W-1:0];
         if (set_done)
            done_q <= 1'b1;
         else if (clr_hit)
            done_q <= 1'b0;
      end
   end

   assign done = done_q;
   assign irq  = done_q && mask_q[DONE_BIT];
endmodule

// File: rtl/rdma_window.sv
module rdma_window
   import rdma_pkg::*;
#(
   parameter int ADDR_W     = 16,
   parameter int PAGE_OFF_W = 8,
   parameter int LOW_BYTES  = 32,
   parameter int PMEM_BASE  = 16'h4000,
   parameter int PMEM_BYTES = 1024,
   parameter int STAT_W     = 8,
   parameter int DONE_BIT   = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [2:0]        cfg_sel,
   input  logic [7:0]        cfg_wdata,
   input  logic              dp_req,
   input  logic              dp_we,
   input  logic [1:0]        dp_size,
   input  logic [31:0]       dp_wdata,
   output logic [31:0]       dp_rdata,
   output logic              dp_rvalid,
   output logic [ADDR_W-1:0] rdma_addr,
   output logic [ADDR_W-1:0] rdma_count,
   output logic              dma_done,
   output logic              irq
);
   localparam int PAGE_W = ADDR_W - PAGE_OFF_W;

   if (ADDR_W < 9 || ADDR_W > 16) begin : g_bad_addr_w
      $error("rdma_window: ADDR_W must lie in 9..16");
   end
   if (PAGE_W < 1 || PAGE_W > 8) begin : g_bad_page
      $error("rdma_window: page number must fit one register byte");
   end
   if ((LOW_BYTES % 4) != 0 || (PMEM_BASE % 4) != 0 || (PMEM_BYTES % 4) != 0) begin : g_bad_align
      $error("rdma_window: memory windows must be word aligned");
   end
   if (PMEM_BASE < LOW_BYTES || PMEM_BASE + PMEM_BYTES > (1 << ADDR_W)) begin : g_bad_window
      $error("rdma_window: packet window overlaps or exceeds address space");
   end
   if (DONE_BIT >= STAT_W || STAT_W > 8) begin : g_bad_stat
      $error("rdma_window: status layout invalid");
   end

   acc_size_e         size_e;
   logic              accept;
   logic              done_hit;
   logic [PAGE_W-1:0] ring_first, ring_last;

   assign size_e = acc_size_e'(dp_size);
   assign accept = dp_req && (size_e != SZ_RSVD) && !(dp_we && rdma_count == '0);

   rdma_ptr #(
      .ADDR_W     (ADDR_W),
      .PAGE_OFF_W (PAGE_OFF_W)
   ) u_ptr (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_we     (cfg_we),
      .cfg_sel    (cfg_sel),
      .cfg_wdata  (cfg_wdata),
      .step_en    (accept),
      .step_bytes (size_bytes(size_e)),
      .addr       (rdma_addr),
      .count      (rdma_count),
      .ring_first (ring_first),
      .ring_last  (ring_last),
      .done_hit   (done_hit)
   );

   rdma_bufram #(
      .ADDR_W     (ADDR_W),
      .LOW_BYTES  (LOW_BYTES),
      .PMEM_BASE  (PMEM_BASE),
      .PMEM_BYTES (PMEM_BYTES)
   ) u_ram (
      .clk      (clk),
      .rst_n    (rst_n),
      .acc_en   (accept),
      .acc_we   (dp_we),
      .acc_size (size_e),
      .acc_addr (rdma_addr),
      .wdata    (dp_wdata),
      .rdata    (dp_rdata),
      .rvalid   (dp_rvalid)
   );

   rdma_irq #(
      .STAT_W   (STAT_W),
      .DONE_BIT (DONE_BIT)
   ) u_irq (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_done  (done_hit),
      .cfg_we    (cfg_we),
      .cfg_sel   (cfg_sel),
      .cfg_wdata (cfg_wdata),
      .done      (dma_done),
      .irq       (irq)
   );
endmodule

// File: rtl/rdma_window_chk.sv
module rdma_window_chk #(
   parameter int ADDR_W     = 16,
   parameter int PAGE_OFF_W = 8
) (
   input logic                         clk,
   input logic                         rst_n,
   input logic                         cfg_we,
   input logic                         dp_req,
   input logic                         dp_we,
   input logic [1:0]                   dp_size,
   input logic                         dp_rvalid,
   input logic [ADDR_W-1:0]            rdma_addr,
   input logic [ADDR_W-1:0]            rdma_count,
   input logic                         dma_done,
   input logic                         irq,
   input logic [ADDR_W-PAGE_OFF_W-1:0] ring_first,
   input logic [ADDR_W-PAGE_OFF_W-1:0] ring_last
);
   logic [ADDR_W-1:0] word_step, last_bound, first_bound;
   assign word_step   = rdma_addr + ADDR_W'(4);
   assign last_bound  = {ring_last,  {PAGE_OFF_W{1'b0}}};
   assign first_bound = {ring_first, {PAGE_OFF_W{1'b0}}};

   // R1: byte access drops the count by one
   a_r1_byte_count: assert property (@(posedge clk) disable iff (!rst_n)
      (dp_req && dp_size == 2'd0 && !(dp_we && rdma_count == '0) && !cfg_we)
      |=> rdma_count == $past(rdma_count) - ADDR_W'(1));

   // R2: write at zero count leaves the pointers alone
   a_r2_zero_write_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (dp_req && dp_we && rdma_count == '0 && !cfg_we)
      |=> ($stable(rdma_addr) && $stable(rdma_count)));

   // R3: a word step landing on the last boundary reloads the first page
   a_r3_ring_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (dp_req && dp_size == 2'd2 && rdma_count != '0 && !cfg_we
       && word_step == last_bound)
      |=> rdma_addr == $past(first_bound));

   // R4: halfword access at count two completes the transfer
   a_r4_done_rise: assert property (@(posedge clk) disable iff (!rst_n)
      (dp_req && dp_size == 2'd1 && rdma_count == ADDR_W'(2))
      |=> dma_done);

   // R8: interrupt never without the status bit
   a_r8_irq_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
      !dma_done |-> !irq);

   // R9: a valid read request yields read data next cycle
   a_r9_read_valid: assert property (@(posedge clk) disable iff (!rst_n)
      (dp_req && !dp_we && dp_size != 2'd3) |=> dp_rvalid);

   // R11: reserved width changes nothing
   a_r11_rsvd_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (dp_req && dp_size == 2'd3 && !cfg_we)
      |=> ($stable(rdma_addr) && $stable(rdma_count) && !dp_rvalid));
endmodule

bind rdma_window rdma_window_chk #(
   .ADDR_W     (ADDR_W),
   .PAGE_OFF_W (PAGE_OFF_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cfg_we     (cfg_we),
   .dp_req     (dp_req),
   .dp_we      (dp_we),
   .dp_size    (dp_size),
   .dp_rvalid  (dp_rvalid),
   .rdma_addr  (rdma_addr),
   .rdma_count (rdma_count),
   .dma_done   (dma_done),
   .irq        (irq),
   .ring_first (ring_first),
   .ring_last  (ring_last)
);

// File: tb/rdma_window_bench.sv
module rdma_window_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [2:0]  cfg_sel = '0;
   logic [7:0]  cfg_wdata = '0;
   logic        dp_req = 1'b0;
   logic        dp_we = 1'b0;
   logic [1:0]  dp_size = '0;
   logic [31:0] dp_wdata = '0;
   logic [31:0] dp_rdata;
   logic        dp_rvalid;
   logic [15:0] rdma_addr, rdma_count;
   logic        dma_done, irq;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   rdma_window u_rdma_window (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .dp_req(dp_req), .dp_we(dp_we),
      .dp_size(dp_size), .dp_wdata(dp_wdata), .dp_rdata(dp_rdata),
      .dp_rvalid(dp_rvalid), .rdma_addr(rdma_addr), .rdma_count(rdma_count),
      .dma_done(dma_done), .irq(irq)
   );

   task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic cfg(logic [2:0] sel, logic [7:0] data);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic set_ptr(logic [15:0] a, logic [15:0] c);
      cfg(3'd0, a[7:0]); cfg(3'd1, a[15:8]);
      cfg(3'd2, c[7:0]); cfg(3'd3, c[15:8]);
   endtask

   task automatic acc(logic we, logic [1:0] sz, logic [31:0] wd, output logic [31:0] rd);
      @(negedge clk);
      dp_req = 1'b1; dp_we = we; dp_size = sz; dp_wdata = wd;
      @(negedge clk);
      dp_req = 1'b0; dp_we = 1'b0;
      rd = dp_rdata;
   endtask

   task automatic rd_at(logic [15:0] a, logic [1:0] sz, output logic [31:0] rd);
      set_ptr(a, 16'd4);
      acc(1'b0, sz, '0, rd);
   endtask

   task automatic t_reset;
      chk("R12", "addr", rdma_addr, 0);
      chk("R12", "count", rdma_count, 0);
      chk("R12", "done", dma_done, 0);
      chk("R12", "irq", irq, 0);
      chk("R12", "rvalid", dp_rvalid, 0);
   endtask

   task automatic t_endian;
      logic [31:0] r;
      cfg(3'd4, 8'h40); cfg(3'd5, 8'h43);
      set_ptr(16'h4000, 16'd4);
      acc(1'b1, 2'd2, 32'h1122_3344, r);
      chk("R9", "rvalid after write", dp_rvalid, 0);
      rd_at(16'h4000, 2'd0, r); chk("R7", "byte0", r, 32'h44);
      chk("R9", "rvalid after read", dp_rvalid, 1);
      rd_at(16'h4003, 2'd0, r); chk("R7", "byte3", r, 32'h11);
      rd_at(16'h4002, 2'd1, r); chk("R7", "upper half", r, 32'h1122);
      rd_at(16'h4000, 2'd2, r); chk("R7", "word", r, 32'h1122_3344);
      set_ptr(16'h0004, 16'd4);
      acc(1'b1, 2'd2, 32'hDEAD_BEEF, r);
      rd_at(16'h0004, 2'd2, r); chk("R6", "low region word", r, 32'hDEAD_BEEF);
   endtask

   task automatic t_steps;
      logic [31:0] r;
      set_ptr(16'h4000, 16'd10);
      acc(1'b1, 2'd0, 32'h1, r);
      chk("R1", "addr after byte", rdma_addr, 16'h4001);
      chk("R1", "count after byte", rdma_count, 9);
      acc(1'b1, 2'd1, 32'h2, r);
      chk("R1", "addr after half", rdma_addr, 16'h4003);
      chk("R1", "count after half", rdma_count, 7);
      acc(1'b1, 2'd2, 32'h3, r);
      chk("R1", "addr after word", rdma_addr, 16'h4007);
      chk("R1", "count after word", rdma_count, 3);
   endtask

   task automatic t_align;
      logic [31:0] r;
      set_ptr(16'h4011, 16'd2);
      acc(1'b1, 2'd1, 32'h0000_BEEF, r);
      chk("R5", "addr from odd half", rdma_addr, 16'h4013);
      rd_at(16'h4010, 2'd0, r); chk("R5", "half lands low", r, 32'hEF);
      rd_at(16'h4011, 2'd0, r); chk("R5", "half high byte", r, 32'hBE);
      set_ptr(16'h4023, 16'd4);
      acc(1'b1, 2'd2, 32'hCAFE_F00D, r);
      chk("R5", "addr from odd word", rdma_addr, 16'h4027);
      rd_at(16'h4020, 2'd0, r); chk("R5", "word lands aligned", r, 32'h0D);
   endtask

   task automatic t_unbacked;
      logic [31:0] r;
      rd_at(16'h0100, 2'd0, r); chk("R6", "gap byte", r, 32'hFF);
      rd_at(16'h0100, 2'd1, r); chk("R6", "gap half", r, 32'hFFFF);
      rd_at(16'h0100, 2'd2, r); chk("R6", "gap word", r, 32'hFFFF_FFFF);
      rd_at(16'h0020, 2'd0, r); chk("R6", "just above low", r, 32'hFF);
      rd_at(16'h4400, 2'd0, r); chk("R6", "just above window", r, 32'hFF);
      set_ptr(16'h001F, 16'd1);
      acc(1'b1, 2'd0, 32'h9C, r);
      rd_at(16'h001F, 2'd0, r); chk("R6", "top of low region", r, 32'h9C);
      set_ptr(16'h43FF, 16'd1);
      acc(1'b1, 2'd0, 32'h6B, r);
      rd_at(16'h43FF, 2'd0, r); chk("R6", "top of window", r, 32'h6B);
   endtask

   task automatic t_zero_write;
      logic [31:0] r;
      set_ptr(16'h4100, 16'd1);
      acc(1'b1, 2'd0, 32'h55, r);
      set_ptr(16'h4100, 16'd0);
      acc(1'b1, 2'd0, 32'hAA, r);
      chk("R2", "addr held", rdma_addr, 16'h4100);
      chk("R2", "count held", rdma_count, 0);
      rd_at(16'h4100, 2'd0, r); chk("R2", "memory untouched", r, 32'h55);
   endtask

   task automatic t_wrap;
      logic [31:0] r;
      cfg(3'd7, 8'h40);
      cfg(3'd4, 8'h40); cfg(3'd5, 8'h42);
      set_ptr(16'h41FC, 16'd8);
      acc(1'b1, 2'd2, 32'hA1A2_A3A4, r);
      chk("R3", "wrapped to first page", rdma_addr, 16'h4000);
      chk("R3", "count mid", rdma_count, 4);
      acc(1'b1, 2'd2, 32'hB1B2_B3B4, r);
      chk("R3", "continued after wrap", rdma_addr, 16'h4004);
      chk("R4", "done on last word", dma_done, 1);
      rd_at(16'h4000, 2'd2, r); chk("R3", "data at first page", r, 32'hB1B2_B3B4);
      rd_at(16'h41FC, 2'd2, r); chk("R3", "data before boundary", r, 32'hA1A2_A3A4);
      chk("R3", "read also wraps", rdma_addr, 16'h4000);
   endtask

   task automatic t_complete;
      logic [31:0] r;
      cfg(3'd7, 8'h40);
      cfg(3'd6, 8'h40);
      set_ptr(16'h4080, 16'd6);
      acc(1'b1, 2'd1, 32'h1, r);
      chk("R4", "not done after first", dma_done, 0);
      acc(1'b1, 2'd1, 32'h2, r);
      chk("R4", "not done after second", dma_done, 0);
      chk("R8", "irq low before end", irq, 0);
      acc(1'b1, 2'd1, 32'h3, r);
      chk("R4", "done on exact final", dma_done, 1);
      chk("R8", "irq with mask", irq, 1);
      cfg(3'd6, 8'h00);
      chk("R8", "irq masked off", irq, 0);
      cfg(3'd7, 8'hBF);
      chk("R8", "clear without bit keeps", dma_done, 1);
      cfg(3'd7, 8'h40);
      chk("R8", "write one clears", dma_done, 0);
      set_ptr(16'h4000, 16'd0);
      acc(1'b0, 2'd0, 32'h0, r);
      chk("R4", "read at zero wraps count", rdma_count, 16'hFFFF);
      chk("R4", "read at zero not done", dma_done, 0);
      chk("R4", "read at zero advances", rdma_addr, 16'h4001);
   endtask

   task automatic t_collide;
      logic [31:0] r;
      cfg(3'd6, 8'h40);
      set_ptr(16'h4090, 16'd1);
      @(negedge clk);
      dp_req = 1'b1; dp_we = 1'b1; dp_size = 2'd0; dp_wdata = 32'h77;
      cfg_we = 1'b1; cfg_sel = 3'd7; cfg_wdata = 8'h40;
      @(negedge clk);
      dp_req = 1'b0; dp_we = 1'b0; cfg_we = 1'b0;
      chk("R8", "set wins over clear", dma_done, 1);
      chk("R8", "irq held in collision", irq, 1);
      set_ptr(16'h4010, 16'd4);
      @(negedge clk);
      dp_req = 1'b1; dp_we = 1'b1; dp_size = 2'd0; dp_wdata = 32'h5A;
      cfg_we = 1'b1; cfg_sel = 3'd0; cfg_wdata = 8'h80;
      @(negedge clk);
      dp_req = 1'b0; dp_we = 1'b0; cfg_we = 1'b0;
      chk("R10", "register write beats step", rdma_addr, 16'h4080);
      chk("R10", "count still steps", rdma_count, 3);
      rd_at(16'h4010, 2'd0, r); chk("R10", "memory used old addr", r, 32'h5A);
   endtask

   task automatic t_reserved;
      logic [31:0] r;
      set_ptr(16'h4000, 16'd4);
      acc(1'b1, 2'd3, 32'hFFFF_FFFF, r);
      chk("R11", "addr unchanged", rdma_addr, 16'h4000);
      chk("R11", "count unchanged", rdma_count, 4);
      acc(1'b0, 2'd3, 32'h0, r);
      chk("R11", "no rvalid", dp_rvalid, 0);
      rd_at(16'h4000, 2'd2, r); chk("R11", "memory unchanged", r, 32'hB1B2_B3B4);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_endian;
      t_steps;
      t_align;
      t_unbacked;
      t_zero_write;
      t_wrap;
      t_complete;
      t_collide;
      t_reserved;
      if (!finished) begin
         finished = 1'b1;
         $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   end
endmodule